// File: doc/BRIEF.md
# Time-Shared Wide Unsigned Multiplier

This block forms the full 64-bit unsigned product of two 32-bit operands using a single pipelined 18x18 multiplier instead of four. Each operand is split into an 18-bit low limb and a 14-bit high limb. The four limb sub-products of a pair are pushed through the shared multiplier one after another. The returning products are shifted by their weight and summed in a per-pair accumulator.

The multiplier has three pipeline stages. A scheduler therefore keeps three slots and gives each one an issue turn in a fixed rotation, one slot per cycle. A slot's product comes back exactly when that slot's next turn arrives. Up to three pairs share the multiplier at once, so three pairs finish every twelve cycles. The input uses a ready/valid handshake, and the output is a single-cycle `done_o` pulse with the product.

Top module: `wide_mul_sched`

## Requirements
- R1: When `done_o` is high, `result_o` equals the full 64-bit unsigned product of the two operands of the pair it belongs to. This includes the carries across the 18-bit limb boundary, with zero and all-ones operands.
- R2: A pair accepted in cycle t (`in_valid_i` and `in_ready_o` both high at the rising edge ending t) produces exactly one `done_o` pulse, in cycle t+13. `done_o` is never high without such an acceptance.
- R3: The slot that takes a pair in cycle t is busy on its turns at t+3, t+6 and t+9, so `in_ready_o` is low in those cycles. It frees on its final turn, so `in_ready_o` is high at t+12.
- R4: With `in_valid_i` held high from an idle state, pairs are accepted in three consecutive cycles, then none for nine cycles, and the pattern repeats. That gives three pairs every twelve cycles.
- R5: Results leave in the order in which their pairs were accepted.
- R6: An input offered while `in_ready_o` is low is not taken. It produces no result and does not disturb the result stream.
- R7: While `rst_ni` is low, and right after it rises, `in_ready_o` is high, `done_o` is low and `result_o` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Operand pair offered |
| in_ready_o | output | 1 | Slot whose turn it is can take a pair |
| a_i | input | 32 | Unsigned operand A |
| b_i | input | 32 | Unsigned operand B |
| done_o | output | 1 | Product valid, one cycle per pair |
| result_o | output | 64 | Unsigned product, held between pulses |

## Verification
Errors in the slot's sub-product index or accumulator show up as a wrong `result_o` exactly 13 cycles after acceptance. A misplaced shift distorts only products whose high limbs are nonzero, so limb-boundary operands are driven on purpose. If the rotating turn pointer and the multiplier latency fall out of step, a slot adds another slot's sub-product. That corrupts neighbouring results within one twelve-cycle window. A wrong busy or free state shows up at once in the `in_ready_o` pattern: either the acceptance cadence under sustained traffic breaks, or a `done_o` appears with nothing expected.

// File: rtl/wmul_pkg.sv
package wmul_pkg;

  typedef enum logic [1:0] {
    SP_LL = 2'd0,  // a_lo * b_lo, weight 1
    SP_LH = 2'd1,  // a_lo * b_hi, weight 2^L
    SP_HL = 2'd2,  // a_hi * b_lo, weight 2^L
    SP_HH = 2'd3   // a_hi * b_hi, weight 2^2L
  } sub_idx_e;

  localparam int unsigned SUB_CNT = 4;
  localparam int unsigned MUL_LAT = 3;

  // number of high limbs in a sub-product -> shift in limb units
  function automatic int unsigned sub_weight(input logic [1:0] k);
    return 32'(k[0]) + 32'(k[1]);
  endfunction

endpackage

// File: rtl/wmul_limb_sel.sv
module wmul_limb_sel #(
  parameter int unsigned OP_W   = 32,
  parameter int unsigned LIMB_W = 18
) (
  input  logic [OP_W-1:0]   a_i,
  input  logic [OP_W-1:0]   b_i,
  input  logic [1:0]        idx_i,
  output logic [LIMB_W-1:0] la_o,
  output logic [LIMB_W-1:0] lb_o
);
  localparam int unsigned HI_W = OP_W - LIMB_W;

  logic [LIMB_W-1:0] a_lo, a_hi, b_lo, b_hi;

  assign a_lo = a_i[LIMB_W-1:0];
  assign b_lo = b_i[LIMB_W-1:0];
  assign a_hi = LIMB_W'(a_i[OP_W-1:OP_W-HI_W]);
  assign b_hi = LIMB_W'(b_i[OP_W-1:OP_W-HI_W]);

  // bit 1 picks the A limb, bit 0 the B limb
  assign la_o = idx_i[1] ? a_hi : a_lo;
  assign lb_o = idx_i[0] ? b_hi : b_lo;
endmodule

// File: rtl/wmul_mul_pipe.sv
module wmul_mul_pipe #(
  parameter int unsigned W = 18
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] p_o
);
  localparam int unsigned H   = W / 2;
  localparam int unsigned P_W = 2 * W;

  logic [W-1:0]     a_r, b_r;
  logic [W+H-1:0]   pp_lo_r;
  logic [2*W-H-1:0] pp_hi_r;
  logic [P_W-1:0]   p_r;

  // stage 1: capture operands
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_r <= '0;
      b_r <= '0;
    end else begin
      a_r <= a_i;
      b_r <= b_i;
    end
  end

  // stage 2: two half-width partial products
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pp_lo_r <= '0;
      pp_hi_r <= '0;
    end else begin
      pp_lo_r <= (W+H)'(a_r) * (W+H)'(b_r[H-1:0]);
      pp_hi_r <= (2*W-H)'(a_r) * (2*W-H)'(b_r[W-1:H]);
    end
  end

  // stage 3: combine halves
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) p_r <= '0;
    else         p_r <= P_W'(pp_lo_r) + (P_W'(pp_hi_r) << H);
  end

  assign p_o = p_r;
endmodule

// File: rtl/wmul_slot.sv
module wmul_slot
  import wmul_pkg::*;
#(
  parameter int unsigned OP_W   = 32,
  parameter int unsigned LIMB_W = 18,
  parameter int unsigned RES_W  = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                turn_i,
  input  logic                load_i,
  input  logic [OP_W-1:0]     a_i,
  input  logic [OP_W-1:0]     b_i,
  input  logic [2*LIMB_W-1:0] prod_i,
  output logic                busy_o,
  output logic                fin_o,
  output logic [RES_W-1:0]    sum_o,
  output logic [LIMB_W-1:0]   nxt_a_o,
  output logic [LIMB_W-1:0]   nxt_b_o
);
  logic [OP_W-1:0]  a_q, b_q;
  logic [1:0]       idx_q;   // sub-product now in flight
  logic [1:0]       idx_nxt;
  logic [RES_W-1:0] acc_q;
  logic             busy_q;

  assign idx_nxt = idx_q + 2'd1;
  assign sum_o   = acc_q + (RES_W'(prod_i) << (LIMB_W * sub_weight(idx_q)));
  assign busy_o  = busy_q;
  assign fin_o   = busy_q && (idx_q == SP_HH);

  wmul_limb_sel #(.OP_W(OP_W), .LIMB_W(LIMB_W)) u_sel (
    .a_i  (a_q),
    .b_i  (b_q),
    .idx_i(idx_nxt),
    .la_o (nxt_a_o),
    .lb_o (nxt_b_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q    <= '0;
      b_q    <= '0;
      idx_q  <= SP_LL;
      acc_q  <= '0;
      busy_q <= 1'b0;
    end else if (load_i) begin
      a_q    <= a_i;
      b_q    <= b_i;
      idx_q  <= SP_LL;
      acc_q  <= '0;
      busy_q <= 1'b1;
    end else if (turn_i && busy_q) begin
      acc_q <= sum_o;
      idx_q <= idx_nxt;
      if (idx_q == SP_HH) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/wide_mul_sched.sv
module wide_mul_sched
  import wmul_pkg::*;
#(
  parameter int unsigned OP_W   = 32,
  parameter int unsigned LIMB_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [OP_W-1:0]   a_i,
  input  logic [OP_W-1:0]   b_i,
  output logic              done_o,
  output logic [2*OP_W-1:0] result_o
);
  localparam int unsigned RES_W = 2 * OP_W;
  localparam int unsigned P_W   = 2 * LIMB_W;
  localparam int unsigned SLOTS = MUL_LAT;  // one slot per pipeline stage
  localparam int unsigned PTR_W = $clog2(SLOTS);

  logic [PTR_W-1:0]  ptr_q;
  logic [SLOTS-1:0]  turn, load, busy, fin;
  logic [RES_W-1:0]  sum   [SLOTS];
  logic [LIMB_W-1:0] nxt_a [SLOTS];
  logic [LIMB_W-1:0] nxt_b [SLOTS];

  logic              cur_busy, cur_fin, accept;
  logic [RES_W-1:0]  cur_sum;
  logic [LIMB_W-1:0] cur_na, cur_nb, in_la, in_lb, mul_a, mul_b;
  logic [P_W-1:0]    prod;
  logic              done_q;
  logic [RES_W-1:0]  res_q;

  // issue turn rotates one slot per cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          ptr_q <= '0;
    else if (ptr_q == PTR_W'(SLOTS - 1))  ptr_q <= '0;
    else                                  ptr_q <= ptr_q + 1'b1;
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign turn[s] = (ptr_q == PTR_W'(s));
    assign load[s] = accept && turn[s];

    wmul_slot #(.OP_W(OP_W), .LIMB_W(LIMB_W), .RES_W(RES_W)) u_slot (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .turn_i (turn[s]),
      .load_i (load[s]),
      .a_i    (a_i),
      .b_i    (b_i),
      .prod_i (prod),
      .busy_o (busy[s]),
      .fin_o  (fin[s]),
      .sum_o  (sum[s]),
      .nxt_a_o(nxt_a[s]),
      .nxt_b_o(nxt_b[s])
    );
  end

  always_comb begin
    cur_busy = 1'b0;
    cur_fin  = 1'b0;
    cur_sum  = '0;
    cur_na   = '0;
    cur_nb   = '0;
    for (int s = 0; s < SLOTS; s++) begin
      if (turn[s]) begin
        cur_busy = busy[s];
        cur_fin  = fin[s];
        cur_sum  = sum[s];
        cur_na   = nxt_a[s];
        cur_nb   = nxt_b[s];
      end
    end
  end

  // a finishing slot frees in the same turn
  assign in_ready_o = !cur_busy || cur_fin;
  assign accept     = in_valid_i && in_ready_o;

  wmul_limb_sel #(.OP_W(OP_W), .LIMB_W(LIMB_W)) u_in_sel (
    .a_i  (a_i),
    .b_i  (b_i),
    .idx_i(SP_LL),
    .la_o (in_la),
    .lb_o (in_lb)
  );

  always_comb begin
    if (accept) begin
      mul_a = in_la;
      mul_b = in_lb;
    end else if (cur_busy && !cur_fin) begin
      mul_a = cur_na;
      mul_b = cur_nb;
    end else begin
      mul_a = '0;
      mul_b = '0;
    end
  end

  wmul_mul_pipe #(.W(LIMB_W)) u_mul (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .a_i   (mul_a),
    .b_i   (mul_b),
    .p_o   (prod)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      res_q  <= '0;
    end else begin
      done_q <= cur_fin;
      if (cur_fin) res_q <= cur_sum;
    end
  end

  assign done_o   = done_q;
  assign result_o = res_q;
endmodule

// File: rtl/wmul_chk.sv
module wmul_chk #(
  parameter int unsigned OP_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic [OP_W-1:0]   a_i,
  input logic [OP_W-1:0]   b_i,
  input logic              done_o,
  input logic [2*OP_W-1:0] result_o
);
  localparam int unsigned RES_W = 2 * OP_W;

  logic [4:0] cyc;
  logic       acc;

  assign acc = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cyc <= '0;
    else if (cyc != 5'd20) cyc <= cyc + 5'd1;
  end

  p_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc >= 5'd14 && $past(acc, 13)) |-> done_o);

  p_done_src_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc >= 5'd14 && done_o) |-> $past(acc, 13));

  p_product_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc >= 5'd14 && done_o) |->
      result_o == RES_W'($past(a_i, 13)) * RES_W'($past(b_i, 13)));

  p_slot_held_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc >= 5'd4 && $past(acc, 3)) |-> !in_ready_o);

  p_slot_free_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc >= 5'd13 && $past(acc, 12)) |-> in_ready_o);

  p_quiet_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc < 5'd13) |-> !done_o);
endmodule

bind wide_mul_sched wmul_chk #(.OP_W(OP_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .in_valid_i(in_valid_i),
  .in_ready_o(in_ready_o),
  .a_i       (a_i),
  .b_i       (b_i),
  .done_o    (done_o),
  .result_o  (result_o)
);

// File: tb/sim_wide_mul_sched.sv
`timescale 1ns/1ps
module sim_wide_mul_sched;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] a_in = '0, b_in = '0;
  logic        done;
  logic [63:0] result;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int accepted = 0;
  int done_seen = 0;

  typedef struct {
    logic [63:0] prod;
    int          at;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wide_mul_sched u0 (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .in_valid_i(in_valid),
    .in_ready_o(in_ready),
    .a_i       (a_in),
    .b_i       (b_in),
    .done_o    (done),
    .result_o  (result)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: holds valid until the pair is taken
  task automatic send(input logic [31:0] a, input logic [31:0] b, output int at);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1;
    a_in = a;
    b_in = b;
    while (!in_ready) @(negedge clk);
    at = cyc;
    e.prod = 64'(a) * 64'(b);
    e.at = at;
    sb.push_back(e);
    accepted++;
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      done_seen++;
      if (sb.size() == 0) begin
        check(1'b0, "R6 R2 unexpected done", 64'(result), 64'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(result == e.prod, "R1 R5 product", result, e.prod);
        check(cyc == e.at + 13, "R2 latency", 64'(cyc), 64'(e.at + 13));
      end
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin
    int t;
    int acc_at[12];
    logic [31:0] x;

    // R7 reset state
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1, "R7 ready in reset", 64'(in_ready), 64'd1);
    check(done == 1'b0, "R7 done in reset", 64'(done), 64'd0);
    check(result == 64'd0, "R7 result in reset", result, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1 && done == 1'b0 && result == 64'd0, "R7 after reset",
          {62'd0, in_ready, done}, 64'd2);

    // R3 slot occupancy for a lone pair
    send(32'd3, 32'd5, t);
    idle();
    while (cyc < t + 3) @(negedge clk);
    check(!in_ready, "R3 busy at t+3", 64'(in_ready), 64'd0);
    while (cyc < t + 6) @(negedge clk);
    check(!in_ready, "R3 busy at t+6", 64'(in_ready), 64'd0);
    while (cyc < t + 9) @(negedge clk);
    check(!in_ready, "R3 busy at t+9", 64'(in_ready), 64'd0);
    while (cyc < t + 12) @(negedge clk);
    check(in_ready, "R3 free at t+12", 64'(in_ready), 64'd1);
    repeat (4) @(negedge clk);

    // R1 limb-boundary corner operands
    send(32'hFFFF_FFFF, 32'hFFFF_FFFF, t);
    send(32'h0000_0000, 32'hDEAD_BEEF, t);
    send(32'h0003_FFFF, 32'h0003_FFFF, t);
    send(32'h0004_0000, 32'h0004_0000, t);
    send(32'hFFFC_0000, 32'h0003_FFFF, t);
    send(32'h8000_0001, 32'hFFFF_FFFF, t);
    idle();
    repeat (30) @(negedge clk);

    // R4 R6 sustained traffic, valid held through stalls
    x = 32'h1234_5678;
    for (int i = 0; i < 12; i++) begin
      logic [31:0] a, b;
      x = x * 32'd1664525 + 32'd1013904223;
      a = x;
      x = x * 32'd1664525 + 32'd1013904223;
      b = x;
      send(a, b, acc_at[i]);
    end
    idle();
    check(acc_at[2] - acc_at[0] == 2, "R4 three back-to-back", 64'(acc_at[2] - acc_at[0]), 64'd2);
    check(acc_at[3] - acc_at[0] == 12, "R4 fourth after twelve", 64'(acc_at[3] - acc_at[0]), 64'd12);
    check(acc_at[5] - acc_at[3] == 2, "R4 second group back-to-back", 64'(acc_at[5] - acc_at[3]), 64'd2);
    check(acc_at[9] - acc_at[0] == 36, "R4 rate three per twelve", 64'(acc_at[9] - acc_at[0]), 64'd36);

    repeat (30) @(negedge clk);
    check(done_seen == accepted, "R6 one result per accepted pair", 64'(done_seen), 64'(accepted));
    check(sb.size() == 0, "R2 all results seen", 64'(sb.size()), 64'd0);
    finish_run();
  end
endmodule